// File: doc/BRIEF.md
# Segmented Logical Address Translator

This block converts a logical address, made of an access class, an optional segment override and a 32-bit offset, into a 32-bit linear address. It holds six 16-bit segment selector registers (code, data, stack and three extra segments) and a parameterised descriptor table. Each descriptor has a base, a limit, execute/read/write rights and a privilege level. The access class picks a default segment. That segment's selector points at a descriptor. The offset is added to the descriptor base and checked against the limit, the rights and the requester's privilege level.

A small state machine holds the outcome of each cycle. `ST_IDLE` means no request was made. `ST_GRANT` means the translation was accepted. `ST_REFUSE` means the translation faulted. From any state the next state is `ST_IDLE` when `req` is low. It is `ST_REFUSE` when a request faults and `ST_GRANT` when a request passes. Selector registers and descriptors are loaded through one synchronous write port.

Top module: `segx_top`

## Requirements
- R1: With no override, the access class picks the segment register. Class 0 (fetch) uses the code register (index 0). Classes 1 (load) and 2 (store) use the data register (index 1). Classes 3 (pop) and 4 (push) use the stack register (index 2). Classes 5 to 7 behave as a load.
- R2: When `ovr_en` is high and `ovr_seg` is 0 to 5, that register is used instead. The extra registers are 3, 4 and 5, and they are reached only this way. An `ovr_seg` of 6 or 7 is ignored and the default register is used.
- R3: A request that passes its checks gives `out_valid`=1, `out_fault`=0 and `out_lin` = (base + offset) mod 2^32 in the cycle after `req`.
- R4: The descriptor used is the one indexed by the low log2(NUM_DESC) bits of the selected selector. The upper selector bits are ignored.
- R5: An offset greater than the descriptor limit gives `out_fault`=1 (limit fault), `out_valid`=0 and `out_lin`=0. An offset equal to the limit is accepted. A limit fault takes priority over a protection fault.
- R6: A protection fault gives `out_fault`=2, `out_valid`=0 and `out_lin`=0. It is raised by any of these: a fetch from a descriptor without execute, a store or push to one without write, a load or pop from one without read, or `cpl` numerically greater than the descriptor level.
- R7: When `wr_en` is high and `wr_tgt`=0, `wr_sel` is loaded into segment register `wr_idx`. A `wr_idx` of 6 or 7 is ignored. When `wr_en` is high and `wr_tgt`=1, the base, limit, rights and level are loaded into descriptor `wr_idx`. A request in the same cycle as a write sees the old contents.
- R8: After reset, and in the cycle after a cycle with `req` low, all outputs are 0. Reset clears all selectors to 0 and all descriptors to base 0, limit 0, no rights and level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Translation request |
| acc | input | 3 | Access class (0 fetch, 1 load, 2 store, 3 pop, 4 push) |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 3 | Override segment register index |
| offset | input | 32 | Offset within the segment |
| cpl | input | 2 | Current privilege level (0 most privileged) |
| wr_en | input | 1 | Write port enable |
| wr_tgt | input | 1 | Write target: 0 selector register, 1 descriptor |
| wr_idx | input | WI_W (3) | Register or descriptor index |
| wr_sel | input | 16 | Selector value to load |
| wr_base | input | 32 | Descriptor base to load |
| wr_limit | input | 32 | Descriptor limit to load |
| wr_x | input | 1 | Descriptor execute right |
| wr_r | input | 1 | Descriptor read right |
| wr_w | input | 1 | Descriptor write right |
| wr_dpl | input | 2 | Descriptor privilege level |
| out_valid | output | 1 | Accepted translation |
| out_lin | output | 32 | Linear address (0 unless accepted) |
| out_fault | output | 2 | Fault code: 0 none, 1 limit, 2 protection |

## Verification
Each access class is sent with and without overrides, to each of six descriptors. Some descriptors are code-only, some read-only, some kernel-level and one wraps past 4 GB. This separates wrong default-segment choice from wrong rights checks and wrong address arithmetic. Offsets placed exactly on the limit and one past it separate an off-by-one limit compare from a correct one. Offsets that break the limit and the rights at once show the fault priority. A write issued together with a request shows whether the translation reads stale or fresh table contents. Ignored override and write indices are followed by translations that would expose any change. A long pseudo-random run is compared against a behavioural model on every clock.

// File: rtl/segx_pkg.sv
package segx_pkg;
    localparam int SEL_W  = 16;
    localparam int ADDR_W = 32;
    localparam int NSEG   = 6;
    localparam int SEGI_W = 3;

    localparam logic [SEGI_W-1:0] SR_CODE  = 3'd0;
    localparam logic [SEGI_W-1:0] SR_DATA  = 3'd1;
    localparam logic [SEGI_W-1:0] SR_STACK = 3'd2;

    typedef enum logic [2:0] {
        ACC_FETCH = 3'd0,
        ACC_LOAD  = 3'd1,
        ACC_STORE = 3'd2,
        ACC_POP   = 3'd3,
        ACC_PUSH  = 3'd4
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_LIMIT = 2'd1,
        FLT_PROT  = 2'd2
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GRANT  = 2'd1,
        ST_REFUSE = 2'd2
    } st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic              x;
        logic              r;
        logic              w;
        logic [1:0]        dpl;
    } desc_t;
endpackage

// File: rtl/segx_segregs.sv
module segx_segregs
    import segx_pkg::*;
#(
    parameter int N = NSEG
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [SEGI_W-1:0]     widx,
    input  logic [SEL_W-1:0]      wsel,
    output logic [N-1:0][SEL_W-1:0] sels
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                sels[g] <= '0;
            else if (we && (widx == SEGI_W'(g)))
                sels[g] <= wsel;
        end
    end
endmodule

// File: rtl/segx_desc_table.sv
module segx_desc_table
    import segx_pkg::*;
#(
    parameter int NUM_DESC = 8,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  desc_t            wdesc,
    input  logic [IDX_W-1:0] ridx,
    output desc_t            rdesc
);
    desc_t ent [NUM_DESC];

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= '0;
            else if (we && (widx == IDX_W'(g)))
                ent[g] <= wdesc;
        end
    end

    assign rdesc = ent[ridx];
endmodule

// File: rtl/segx_pick.sv
module segx_pick
    import segx_pkg::*;
(
    input  logic [2:0]               acc,
    input  logic                     ovr_en,
    input  logic [SEGI_W-1:0]        ovr_seg,
    input  logic [NSEG-1:0][SEL_W-1:0] sels,
    output logic [SEL_W-1:0]         sel
);
    logic [SEGI_W-1:0] dflt;
    logic [SEGI_W-1:0] seg;

    always_comb begin
        case (acc)
            ACC_FETCH:          dflt = SR_CODE;
            ACC_POP, ACC_PUSH:  dflt = SR_STACK;
            default:            dflt = SR_DATA;
        endcase
    end

    assign seg = (ovr_en && (ovr_seg < SEGI_W'(NSEG))) ? ovr_seg : dflt;
    assign sel = sels[seg];
endmodule

// File: rtl/segx_check.sv
module segx_check
    import segx_pkg::*;
(
    input  logic [2:0]        acc,
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        cpl,
    input  desc_t             d,
    output flt_e              fault,
    output logic [ADDR_W-1:0] lin
);
    logic need_x, need_w, need_r, bad_rights, bad_level, over;

    always_comb begin
        need_x = 1'b0;
        need_w = 1'b0;
        need_r = 1'b0;
        case (acc)
            ACC_FETCH:             need_x = 1'b1;
            ACC_STORE, ACC_PUSH:   need_w = 1'b1;
            default:               need_r = 1'b1;
        endcase
    end

    assign bad_rights = (need_x && !d.x) || (need_w && !d.w) || (need_r && !d.r);
    assign bad_level  = cpl > d.dpl;
    assign over       = offset > d.limit;
    assign lin        = d.base + offset;

    always_comb begin
        if (over)
            fault = FLT_LIMIT;
        else if (bad_rights || bad_level)
            fault = FLT_PROT;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/segx_top.sv
module segx_top
    import segx_pkg::*;
#(
    parameter int NUM_DESC = 8,
    localparam int IDX_W   = $clog2(NUM_DESC),
    localparam int WI_W    = (IDX_W > SEGI_W) ? IDX_W : SEGI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [2:0]        acc,
    input  logic              ovr_en,
    input  logic [2:0]        ovr_seg,
    input  logic [31:0]       offset,
    input  logic [1:0]        cpl,
    input  logic              wr_en,
    input  logic              wr_tgt,
    input  logic [WI_W-1:0]   wr_idx,
    input  logic [15:0]       wr_sel,
    input  logic [31:0]       wr_base,
    input  logic [31:0]       wr_limit,
    input  logic              wr_x,
    input  logic              wr_r,
    input  logic              wr_w,
    input  logic [1:0]        wr_dpl,
    output logic              out_valid,
    output logic [31:0]       out_lin,
    output logic [1:0]        out_fault
);
    logic [NSEG-1:0][SEL_W-1:0] sels;
    logic [SEL_W-1:0]  cur_sel;
    desc_t             cur_desc;
    desc_t             wdesc;
    flt_e              chk_fault;
    logic [ADDR_W-1:0] chk_lin;
    logic              seg_we, desc_we;

    st_e               st_q, st_d;
    logic [ADDR_W-1:0] lin_q;
    flt_e              flt_q;

    // write port decode (R7): selector indices 6 and 7 address nothing
    assign seg_we  = wr_en && !wr_tgt && (wr_idx < WI_W'(NSEG));
    assign desc_we = wr_en && wr_tgt;
    assign wdesc   = '{base: wr_base, limit: wr_limit, x: wr_x, r: wr_r,
                       w: wr_w, dpl: wr_dpl};

    segx_segregs #(.N(NSEG)) u_segregs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seg_we),
        .widx  (wr_idx[SEGI_W-1:0]),
        .wsel  (wr_sel),
        .sels  (sels)
    );

    segx_pick u_pick (
        .acc     (acc),
        .ovr_en  (ovr_en),
        .ovr_seg (ovr_seg),
        .sels    (sels),
        .sel     (cur_sel)
    );

    segx_desc_table #(.NUM_DESC(NUM_DESC)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (desc_we),
        .widx  (wr_idx[IDX_W-1:0]),
        .wdesc (wdesc),
        .ridx  (cur_sel[IDX_W-1:0]),
        .rdesc (cur_desc)
    );

    segx_check u_check (
        .acc    (acc),
        .offset (offset),
        .cpl    (cpl),
        .d      (cur_desc),
        .fault  (chk_fault),
        .lin    (chk_lin)
    );

    // next-state logic
    always_comb begin
        if (!req)
            st_d = ST_IDLE;
        else if (chk_fault != FLT_NONE)
            st_d = ST_REFUSE;
        else
            st_d = ST_GRANT;
    end

    // state register with captured result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            lin_q <= '0;
            flt_q <= FLT_NONE;
        end else begin
            st_q  <= st_d;
            lin_q <= (st_d == ST_GRANT)  ? chk_lin   : '0;
            flt_q <= (st_d == ST_REFUSE) ? chk_fault : FLT_NONE;
        end
    end

    // outputs from state
    always_comb begin
        out_valid = 1'b0;
        out_lin   = '0;
        out_fault = FLT_NONE;
        unique case (st_q)
            ST_IDLE:   ;
            ST_GRANT:  begin
                out_valid = 1'b1;
                out_lin   = lin_q;
            end
            ST_REFUSE: out_fault = flt_q;
            default:   ;
        endcase
    end

    p_valid_no_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_fault == 2'b00));
    p_fault_addr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fault != 2'b00) |-> (out_lin == '0));
    p_fault_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault != 2'b11);
    p_req_answered_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (out_valid || (out_fault != 2'b00)));
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!out_valid && (out_fault == 2'b00) && (out_lin == '0)));
    p_limit_beats_rights_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (offset > cur_desc.limit)) |=> (out_fault == 2'b01));
endmodule

// File: tb/segx_top_bench.sv
module segx_top_bench;
    localparam int ND = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  acc = '0;
    logic        ovr_en = 1'b0;
    logic [2:0]  ovr_seg = '0;
    logic [31:0] offset = '0;
    logic [1:0]  cpl = '0;
    logic        wr_en = 1'b0;
    logic        wr_tgt = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [15:0] wr_sel = '0;
    logic [31:0] wr_base = '0;
    logic [31:0] wr_limit = '0;
    logic        wr_x = 1'b0, wr_r = 1'b0, wr_w = 1'b0;
    logic [1:0]  wr_dpl = '0;
    logic        out_valid;
    logic [31:0] out_lin;
    logic [1:0]  out_fault;

    int tests = 0;
    int fails = 0;

    // behavioural model state
    logic [15:0] m_sel [6];
    logic [31:0] m_base [ND];
    logic [31:0] m_lim [ND];
    bit          m_x [ND], m_r [ND], m_w [ND];
    int          m_dpl [ND];

    always #5 clk = ~clk;

    segx_top #(.NUM_DESC(ND)) u_segx_top (
        .clk(clk), .rst_n(rst_n), .req(req), .acc(acc), .ovr_en(ovr_en),
        .ovr_seg(ovr_seg), .offset(offset), .cpl(cpl), .wr_en(wr_en),
        .wr_tgt(wr_tgt), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_base(wr_base),
        .wr_limit(wr_limit), .wr_x(wr_x), .wr_r(wr_r), .wr_w(wr_w),
        .wr_dpl(wr_dpl), .out_valid(out_valid), .out_lin(out_lin),
        .out_fault(out_fault)
    );

    task automatic compare(input bit ev, input logic [1:0] ef,
                           input logic [31:0] el, input string tag);
        tests++;
        if (out_valid !== ev || out_fault !== ef || out_lin !== el) begin
            fails++;
            $display("FAIL %s: got valid=%0b fault=%0d lin=%h, expected valid=%0b fault=%0d lin=%h",
                     tag, out_valid, out_fault, out_lin, ev, ef, el);
        end
    endtask

    // one clock: drive at negedge, model, compare at following negedge
    task automatic cyc(input bit rq, input int a, input bit oe, input int os,
                       input logic [31:0] off, input int cp,
                       input bit we, input bit wt, input int wi,
                       input logic [15:0] ws, input logic [31:0] wb,
                       input logic [31:0] wl, input bit x, input bit r,
                       input bit w, input int dp);
        int seg, d;
        bit nx, nw, nr, lim, prot;
        bit ev;
        logic [1:0] ef;
        logic [31:0] el;
        string tag;
        req = rq; acc = 3'(a); ovr_en = oe; ovr_seg = 3'(os); offset = off;
        cpl = 2'(cp); wr_en = we; wr_tgt = wt; wr_idx = 3'(wi); wr_sel = ws;
        wr_base = wb; wr_limit = wl; wr_x = x; wr_r = r; wr_w = w;
        wr_dpl = 2'(dp);
        // R1 default choice, R2 override
        if (a == 0) seg = 0;
        else if (a == 3 || a == 4) seg = 2;
        else seg = 1;
        if (oe && os < 6) seg = os;
        d = int'(m_sel[seg]) % ND;           // R4
        nx = (a == 0); nw = (a == 2 || a == 4); nr = !nx && !nw;
        lim = off > m_lim[d];
        prot = (nx && !m_x[d]) || (nw && !m_w[d]) || (nr && !m_r[d]) || (cp > m_dpl[d]);
        if (!rq) begin ev = 0; ef = 0; el = 0; tag = "R8"; end
        else if (lim) begin ev = 0; ef = 2'd1; el = 0; tag = "R5"; end
        else if (prot) begin ev = 0; ef = 2'd2; el = 0; tag = "R6"; end
        else begin ev = 1; ef = 0; el = m_base[d] + off; tag = "R3"; end
        // R7 model update after the lookup
        if (we && !wt && wi < 6) m_sel[wi] = ws;
        if (we && wt) begin
            m_base[wi] = wb; m_lim[wi] = wl; m_x[wi] = x; m_r[wi] = r;
            m_w[wi] = w; m_dpl[wi] = dp;
        end
        @(posedge clk);
        @(negedge clk);
        compare(ev, ef, el, tag);
    endtask

    task automatic tx(input int a, input bit oe, input int os,
                      input logic [31:0] off, input int cp);
        cyc(1, a, oe, os, off, cp, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wseg(input int i, input logic [15:0] s);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, i, s, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wdsc(input int i, input logic [31:0] b, input logic [31:0] l,
                        input bit x, input bit r, input bit w, input int dp);
        cyc(0, 0, 0, 0, 0, 0, 1, 1, i, 0, b, l, x, r, w, dp);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) m_sel[i] = '0;
        for (int i = 0; i < ND; i++) begin
            m_base[i] = 0; m_lim[i] = 0; m_x[i] = 0; m_r[i] = 0; m_w[i] = 0; m_dpl[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare(0, 0, 0, "R8 reset");
        tx(0, 0, 0, 32'h0, 0);             // R8 cleared table: fetch lacks rights (R6)

        // R7 table loads
        wdsc(0, 32'h0000_1000, 32'h0000_0FFF, 1, 1, 0, 0);  // code, kernel
        wdsc(1, 32'h0002_0000, 32'h0000_FFFF, 0, 1, 1, 3);  // data, user
        wdsc(2, 32'h0008_0000, 32'h0000_07FF, 0, 1, 1, 0);  // stack, kernel
        wdsc(3, 32'hFFFF_F000, 32'hFFFF_FFFF, 0, 1, 0, 3);  // wraps, read-only
        wdsc(4, 32'h0004_0000, 32'h0000_0100, 0, 1, 1, 3);
        wdsc(5, 32'h0005_0000, 32'h0000_01FF, 1, 0, 0, 3);  // execute-only
        // R4: upper selector bits differ, low bits index
        wseg(0, 16'hAB80); wseg(1, 16'h0009); wseg(2, 16'h1232);
        wseg(3, 16'h0003); wseg(4, 16'h0004); wseg(5, 16'h0005);
        wseg(6, 16'h0002);                 // R7 ignored index
        wseg(7, 16'h0002);

        // R1 default segments, R3 address sum
        tx(0, 0, 0, 32'h10, 0);
        tx(1, 0, 0, 32'h1234, 3);
        tx(2, 0, 0, 32'hFFFF, 3);
        tx(4, 0, 0, 32'h7FF, 0);           // R5 offset equal to limit
        tx(4, 0, 0, 32'h800, 0);           // R5 one past limit
        tx(3, 0, 0, 32'h10, 3);            // R6 privilege
        tx(0, 0, 0, 32'h10, 1);            // R6 privilege on fetch
        tx(6, 0, 0, 32'h20, 3);            // R1 class 6 acts as load
        // R2 overrides
        tx(0, 1, 1, 32'h0, 0);             // R6 fetch from data
        tx(1, 1, 3, 32'h2000, 3);          // wraps mod 2^32
        tx(2, 1, 3, 32'h0, 0);             // R6 store to read-only
        tx(1, 1, 4, 32'h100, 3);
        tx(1, 1, 5, 32'h0, 3);             // R6 read exec-only
        tx(0, 1, 5, 32'h1FF, 3);
        tx(1, 1, 6, 32'h8, 3);             // R2 override 6 ignored
        tx(4, 1, 7, 32'h8, 0);             // R2 override 7 ignored
        tx(2, 1, 0, 32'h2000, 3);          // R5 limit beats protection
        idle();
        // R7 same-cycle write with request sees old base
        cyc(1, 1, 0, 0, 32'h40, 3, 1, 1, 1, 0, 32'h0030_0000, 32'h0000_FFFF, 0, 1, 1, 3);
        tx(1, 0, 0, 32'h40, 3);
        cyc(1, 1, 0, 0, 32'h40, 3, 1, 0, 1, 16'h0004, 0, 0, 0, 0, 0, 0);
        tx(1, 0, 0, 32'h40, 3);            // R7 new selector now in use

        // mixed pseudo-random traffic against the model
        for (int k = 0; k < 400; k++) begin
            int sel_pick;
            sel_pick = $urandom_range(0, 9);
            if (sel_pick == 0)
                wseg($urandom_range(0, 7), 16'($urandom));
            else if (sel_pick == 1)
                wdsc($urandom_range(0, 7), $urandom, 32'($urandom_range(0, 32'h3000)),
                     1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 3));
            else if (sel_pick == 2)
                idle();
            else
                tx($urandom_range(0, 7), 1'($urandom), $urandom_range(0, 7),
                   32'($urandom_range(0, 32'h3000)), $urandom_range(0, 3));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule